// File: doc/BRIEF.md
# Laser Transmit Enable and Fault Supervisor

This block decides, cycle by cycle, whether an optical transmitter may emit light. It combines a hardware disable pin, a software disable bit, a fault detector input and a supply-good indication, and it counts a free-running microsecond tick to time its windows. It drives a laser enable, a latched fault flag and a ready flag.

After the supply becomes good, the block waits a configurable number of microsecond ticks before it reports ready. The laser stays dark during that wait, and a fault seen then is not latched. Once ready, any fault latches the fault flag and forces the laser off. The flag is sticky. It clears only after the hardware disable pin has been held high for a configurable number of ticks, and only if the fault condition has gone by that time. The software bit turns the laser off but never clears a fault. If the supply is lost, the ready flag and the enable drop at once, the hold window starts again from zero, and any latched fault is discarded.

All inputs are synchronous to `clk`. The enable is a combinational function of the inputs and the registered state, so a disable request turns the laser off in the same cycle.

Top module: `laser_tx_supervisor`

## Requirements
- R1: While `hw_disable` is 1, `laser_en` is 0 in the same cycle. When it returns to 0, `laser_en` returns in the same cycle if nothing else blocks it.
- R2: While `sw_disable` is 1, `laser_en` is 0 in the same cycle. Holding `sw_disable` high for any length of time never clears a latched fault.
- R3: `ready` stays 0 until `supply_good` has been 1 for `HOLD_US` clock edges on which `us_tick` was 1. Edges without a tick do not advance the window. `laser_en` is 0 whenever `ready` is 0.
- R4: When `supply_good` falls, `ready` and `laser_en` go to 0 in the same cycle. At the next edge the hold window restarts from zero and any latched fault is cleared.
- R5: A 1 on `fault_in` while `ready` is 1 sets `fault_latched` at the next clock edge, and `laser_en` is 0 from then on.
- R6: `fault_latched` stays 1 after `fault_in` returns to 0, until the clear rule of R7 applies.
- R7: The fault clears at the first edge where two conditions hold: `hw_disable` has been 1 on at least `CLEAR_US` consecutive tick edges, and `fault_in` is 0. A pulse of exactly `CLEAR_US` ticks that ends at that edge therefore clears the fault. A pulse of `CLEAR_US`-1 ticks does not.
- R8: If `fault_in` is still 1 when the clear pulse completes or ends, the fault remains latched and `laser_en` stays 0.
- R9: A 1 on `fault_in` while `ready` is 0 is not latched.
- R10: When `ready` is 1, both disables are 0 and no fault is latched, `laser_en` is 1.
- R11: While `rst_n` is 0, `laser_en`, `fault_latched` and `ready` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| us_tick | input | 1 | One-cycle pulse each microsecond |
| hw_disable | input | 1 | Hardware transmit disable; 1 = off (pulled high when open) |
| sw_disable | input | 1 | Software transmit disable bit; 1 = off |
| fault_in | input | 1 | Raw laser fault detector; 1 = fault |
| supply_good | input | 1 | Supply above its reset threshold |
| laser_en | output | 1 | Laser may emit |
| fault_latched | output | 1 | Sticky fault indication |
| ready | output | 1 | Power-on hold window has completed |

## Verification
The bench walks the clear pulse across its boundary. A pulse one tick short of `CLEAR_US` must leave the fault set; a counter that is off by one would clear it. A pulse of exactly `CLEAR_US` ticks must clear it; a design that demands an extra tick would not. The bench keeps `fault_in` high through a full clear pulse to catch a clear that takes priority over a new fault. It holds the software bit long to catch a clear wired to the wrong disable. It also injects a fault inside the hold window, where a latch armed too early would stick. A supply drop then restores power, which exposes a window that does not restart or a fault that survives the loss of power.

// File: rtl/lsup_pkg.sv
package lsup_pkg;

  typedef enum logic {
    FLT_IDLE = 1'b0,
    FLT_HELD = 1'b1
  } flt_state_e;

endpackage

// File: rtl/lsup_por_hold.sv
module lsup_por_hold #(
  parameter int HOLD_US = 140000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic us_tick,
  input  logic supply_good,
  output logic done
);

  localparam int CW = $clog2(HOLD_US + 1);
  localparam logic [CW-1:0] HOLD_MAX = CW'(HOLD_US);

  logic [CW-1:0] win_cnt_q;
  logic [CW-1:0] win_cnt_d;
  logic          win_full;

  assign win_full = (win_cnt_q == HOLD_MAX);

  always_comb begin
    win_cnt_d = win_cnt_q;
    if (!supply_good) begin
      win_cnt_d = '0;
    end else if (us_tick && !win_full) begin
      win_cnt_d = win_cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_cnt_q <= '0;
    end else begin
      win_cnt_q <= win_cnt_d;
    end
  end

  assign done = supply_good && win_full;

  assert_ready_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(us_tick));

endmodule

// File: rtl/lsup_fault_latch.sv
module lsup_fault_latch
  import lsup_pkg::*;
#(
  parameter int CLEAR_US = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic us_tick,
  input  logic arm,
  input  logic hw_disable,
  input  logic fault_in,
  output logic fault_q
);

  localparam int CW = $clog2(CLEAR_US + 1);
  localparam logic [CW-1:0] CLR_MAX = CW'(CLEAR_US);

  logic [CW-1:0] pulse_cnt_q;
  logic [CW-1:0] pulse_cnt_d;
  logic          pulse_long;
  flt_state_e    state_q;
  flt_state_e    state_d;

  assign pulse_long = (pulse_cnt_q == CLR_MAX);

  always_comb begin
    pulse_cnt_d = pulse_cnt_q;
    if (!hw_disable) begin
      pulse_cnt_d = '0;
    end else if (us_tick && !pulse_long) begin
      pulse_cnt_d = pulse_cnt_q + 1'b1;
    end
  end

  always_comb begin
    state_d = state_q;
    if (!arm) begin
      state_d = FLT_IDLE;
    end else if (fault_in) begin
      state_d = FLT_HELD;
    end else if (pulse_long) begin
      state_d = FLT_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_cnt_q <= '0;
      state_q     <= FLT_IDLE;
    end else begin
      pulse_cnt_q <= pulse_cnt_d;
      state_q     <= state_d;
    end
  end

  assign fault_q = (state_q == FLT_HELD);

  assert_fault_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (arm && fault_in) |=> fault_q);

  assert_fault_sticks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (arm && fault_q && !pulse_long) |=> fault_q);

  assert_clear_needs_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fault_q) |-> ($past(pulse_long) || !$past(arm)));

endmodule

// File: rtl/laser_tx_supervisor.sv
module laser_tx_supervisor #(
  parameter int HOLD_US  = 140000,
  parameter int CLEAR_US = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic us_tick,
  input  logic hw_disable,
  input  logic sw_disable,
  input  logic fault_in,
  input  logic supply_good,
  output logic laser_en,
  output logic fault_latched,
  output logic ready
);

  logic hold_done;
  logic flt;
  logic any_disable;

  lsup_por_hold #(.HOLD_US(HOLD_US)) u_hold (
    .clk         (clk),
    .rst_n       (rst_n),
    .us_tick     (us_tick),
    .supply_good (supply_good),
    .done        (hold_done)
  );

  lsup_fault_latch #(.CLEAR_US(CLEAR_US)) u_fault (
    .clk        (clk),
    .rst_n      (rst_n),
    .us_tick    (us_tick),
    .arm        (hold_done),
    .hw_disable (hw_disable),
    .fault_in   (fault_in),
    .fault_q    (flt)
  );

  assign any_disable   = hw_disable | sw_disable;
  assign laser_en      = hold_done & ~any_disable & ~flt;
  assign fault_latched = flt;
  assign ready         = hold_done;

  assert_fault_darkens_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_in && ready) |=> !laser_en);

endmodule

// File: tb/sim_laser_tx_supervisor.sv
module sim_laser_tx_supervisor;

  localparam int HOLD = 20;
  localparam int CLR  = 5;

  logic clk, rst_n, us_tick, hw_disable, sw_disable, fault_in, supply_good;
  logic laser_en, fault_latched, ready;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  laser_tx_supervisor #(.HOLD_US(HOLD), .CLEAR_US(CLR)) u0 (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .hw_disable(hw_disable),
    .sw_disable(sw_disable), .fault_in(fault_in), .supply_good(supply_good),
    .laser_en(laser_en), .fault_latched(fault_latched), .ready(ready)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic settle();
    #1;
  endtask

  task automatic chk(input string tag, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: got %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; supply_good = 1'b0; hw_disable = 1'b1; sw_disable = 1'b0;
    fault_in = 1'b0; us_tick = 1'b0;
    cyc(3);
    chk("R11 laser_en", laser_en, 1'b0);
    chk("R11 fault_latched", fault_latched, 1'b0);
    chk("R11 ready", ready, 1'b0);
    rst_n = 1'b1;
    cyc(1);
  endtask

  task automatic t_power_up();
    supply_good = 1'b1; hw_disable = 1'b0; us_tick = 1'b0;
    cyc(10);
    chk("R3 no tick no ready", ready, 1'b0);
    us_tick = 1'b1;
    cyc(HOLD - 1);
    chk("R3 ready one short", ready, 1'b0);
    chk("R3 laser_en in window", laser_en, 1'b0);
    cyc(1);
    chk("R3 ready at hold", ready, 1'b1);
    chk("R10 laser_en on", laser_en, 1'b1);
  endtask

  task automatic t_hw_disable();
    hw_disable = 1'b1; settle();
    chk("R1 pin off", laser_en, 1'b0);
    hw_disable = 1'b0; settle();
    chk("R1 pin released", laser_en, 1'b1);
  endtask

  task automatic t_fault_latch();
    fault_in = 1'b1; cyc(1);
    chk("R5 fault set", fault_latched, 1'b1);
    chk("R5 laser_en off", laser_en, 1'b0);
    fault_in = 1'b0; cyc(3);
    chk("R6 fault sticky", fault_latched, 1'b1);
  endtask

  task automatic t_soft_no_clear();
    sw_disable = 1'b1; cyc(CLR + 3);
    chk("R2 soft keeps fault", fault_latched, 1'b1);
    sw_disable = 1'b0; cyc(1);
    chk("R2 soft keeps fault after", fault_latched, 1'b1);
  endtask

  task automatic t_short_pulse();
    hw_disable = 1'b1; cyc(CLR - 1);
    hw_disable = 1'b0; cyc(2);
    chk("R7 short pulse no clear", fault_latched, 1'b1);
    chk("R7 short pulse laser off", laser_en, 1'b0);
  endtask

  task automatic t_clear();
    hw_disable = 1'b1; cyc(CLR);
    chk("R7 not cleared yet", fault_latched, 1'b1);
    hw_disable = 1'b0; cyc(1);
    chk("R7 cleared", fault_latched, 1'b0);
    chk("R10 laser back", laser_en, 1'b1);
  endtask

  task automatic t_soft_disable();
    sw_disable = 1'b1; settle();
    chk("R2 soft off", laser_en, 1'b0);
    sw_disable = 1'b0; settle();
    chk("R2 soft released", laser_en, 1'b1);
  endtask

  task automatic t_persist();
    fault_in = 1'b1; cyc(1);
    hw_disable = 1'b1; cyc(CLR + 2);
    chk("R8 held during pulse", fault_latched, 1'b1);
    hw_disable = 1'b0; cyc(2);
    chk("R8 relatched", fault_latched, 1'b1);
    chk("R8 laser off", laser_en, 1'b0);
    fault_in = 1'b0;
    hw_disable = 1'b1; cyc(CLR);
    hw_disable = 1'b0; cyc(1);
    chk("R7 clear after persist", fault_latched, 1'b0);
  endtask

  task automatic t_supply_drop();
    fault_in = 1'b1; cyc(1);
    fault_in = 1'b0;
    chk("R5 fault before drop", fault_latched, 1'b1);
    supply_good = 1'b0; settle();
    chk("R4 ready drops", ready, 1'b0);
    chk("R4 laser_en drops", laser_en, 1'b0);
    cyc(1);
    chk("R4 fault discarded", fault_latched, 1'b0);
    supply_good = 1'b1; fault_in = 1'b1;
    cyc(3);
    fault_in = 1'b0;
    cyc(HOLD - 4);
    chk("R4 window restarted", ready, 1'b0);
    chk("R9 window fault ignored", fault_latched, 1'b0);
    cyc(1);
    chk("R4 ready again", ready, 1'b1);
    chk("R9 no fault after window", fault_latched, 1'b0);
    chk("R10 laser on again", laser_en, 1'b1);
  endtask

  initial begin
    t_reset();
    t_power_up();
    t_hw_disable();
    t_soft_disable();
    t_fault_latch();
    t_soft_no_clear();
    t_short_pulse();
    t_clear();
    t_persist();
    t_supply_drop();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(20 * 20000);
    if (!finished) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule